// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This block sequences trap entry and trap return for a single-hart 32-bit integer core that runs only in machine mode. At each instruction boundary it looks at the oldest uncompleted instruction, the exception flags raised for it by decode and execute, and the timer and software interrupt lines from the local interruptor. From these it decides whether a trap is taken and what kind. When a trap is taken it stores the return address and the cause, updates the interrupt-enable stack and sends fetch to the trap vector. It also flushes any younger instruction in that same cycle.

The return address follows one strict rule. A synchronous exception saves the address of the instruction that raised it, and that includes environment calls and breakpoints. An interrupt saves the address of the oldest instruction that has not completed. The hardware never adds an instruction length. To skip an environment call, the handler rewrites the saved PC through the software write port before it executes the machine return. The machine return sends fetch to the saved PC as it stands at that moment and restores the interrupt enable.

Top module: `mtrap_unit`

## Requirements
- R1: When `instr_valid_i` is high and an exception flag is raised with no interrupt taken, a trap is taken with `mcause_o` bit 31 clear and code 2 for illegal instruction, 3 for breakpoint or 11 for environment call. If several flags are raised together, the priority is illegal, then breakpoint, then environment call.
- R2: On any trap, `mepc_o` becomes `instr_pc_i` of the trapping instruction with bits 1:0 forced to zero. Nothing is ever added to it, and this holds for environment calls and breakpoints too.
- R3: An interrupt is taken only when `instr_valid_i` is high, `mstatus_mie_o` is high, and an interrupt line is high together with its enable. `mcause_o` is then 0x80000003 for the software interrupt and 0x80000007 for the timer. Software wins when both qualify.
- R4: When a qualified interrupt and an exception (or a machine return) arrive in the same cycle, the interrupt is taken and `mepc_o` receives that instruction's PC.
- R5: In the cycle a trap is taken, `redirect_valid_o` and `flush_o` are high and `redirect_addr_o` equals `mtvec_i` with bits 1:0 cleared.
- R6: A trapping instruction does not retire: `retire_o` is low, and a software CSR write presented in the same cycle is discarded.
- R7: On trap entry, `mstatus_mpie_o` takes the old `mstatus_mie_o`, and `mstatus_mie_o` is cleared.
- R8: A machine return (`mret_i` with `instr_valid_i` and no trap) raises `redirect_valid_o` and `flush_o` with `redirect_addr_o` equal to the current `mepc_o`. After the edge, `mstatus_mie_o` takes the old `mstatus_mpie_o` and `mstatus_mpie_o` is set.
- R9: The software write port with `csr_sel_i`=0 writes `mepc_o` with bits 1:0 cleared. With `csr_sel_i`=1 it loads `mstatus_mie_o` from data bit 3 and `mstatus_mpie_o` from data bit 7.
- R10: After reset, `mepc_o`, `mcause_o`, `mstatus_mie_o` and `mstatus_mpie_o` are zero.
- R11: With `instr_valid_i` low, no trap or return is taken, and exception flags and interrupt lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Oldest uncompleted instruction is at the boundary |
| instr_pc_i | input | XLEN | PC of that instruction |
| exc_ecall_i | input | 1 | Environment call raised |
| exc_ebreak_i | input | 1 | Breakpoint raised |
| exc_illegal_i | input | 1 | Illegal instruction raised |
| mret_i | input | 1 | Instruction is a machine return |
| irq_timer_i | input | 1 | Timer interrupt pending |
| irq_soft_i | input | 1 | Software interrupt pending |
| en_timer_i | input | 1 | Timer interrupt enable |
| en_soft_i | input | 1 | Software interrupt enable |
| mtvec_i | input | XLEN | Trap vector base |
| csr_we_i | input | 1 | Software write strobe |
| csr_sel_i | input | 1 | 0: saved PC, 1: status bits |
| csr_wdata_i | input | XLEN | Software write data |
| redirect_valid_o | output | 1 | Fetch redirect |
| redirect_addr_o | output | XLEN | Redirect target |
| flush_o | output | 1 | Flush younger instructions |
| retire_o | output | 1 | Boundary instruction completes |
| mepc_we_o | output | 1 | Saved-PC write strobe |
| mcause_we_o | output | 1 | Cause write strobe |
| mepc_o | output | XLEN | Saved PC |
| mcause_o | output | XLEN | Trap cause |
| mstatus_mie_o | output | 1 | Global interrupt enable |
| mstatus_mpie_o | output | 1 | Stacked interrupt enable |

## Verification
Each exception flag is tried alone, which shows that the codes differ and that the saved PC is the instruction's own address. Flags are then combined, which shows the fixed priority. Interrupt lines are tried alone, together, and against each missing qualifier (global enable, line enable, boundary), which separates a taken interrupt from a masked one. Interrupts are also raised in the same cycle as an exception or a machine return, which shows that the interrupt wins and saves the PC of the uncompleted instruction. A handler sequence that rewrites the saved PC and then returns shows that the hardware adds nothing and that the return uses the current saved value.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
   localparam int unsigned CODE_W = 4;

   localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'd2;
   localparam logic [CODE_W-1:0] CODE_BREAK   = 4'd3;
   localparam logic [CODE_W-1:0] CODE_ECALL   = 4'd11;
   localparam logic [CODE_W-1:0] CODE_IRQ_SW  = 4'd3;
   localparam logic [CODE_W-1:0] CODE_IRQ_TMR = 4'd7;

   localparam int unsigned STAT_IE_BIT  = 3;
   localparam int unsigned STAT_PIE_BIT = 7;

   localparam logic SEL_EPC  = 1'b0;
   localparam logic SEL_STAT = 1'b1;

   typedef struct packed {
      logic              take;
      logic              is_irq;
      logic [CODE_W-1:0] code;
   } trap_sel_t;
endpackage

// File: rtl/mtrap_arbiter.sv
module mtrap_arbiter
   import mtrap_pkg::*;
#(
   parameter bit SOFT_OVER_TIMER = 1'b1
) (
   input  logic      boundary_i,
   input  logic      ecall_i,
   input  logic      ebreak_i,
   input  logic      illegal_i,
   input  logic      mret_i,
   input  logic      gie_i,
   input  logic      irq_timer_i,
   input  logic      irq_soft_i,
   input  logic      en_timer_i,
   input  logic      en_soft_i,
   output trap_sel_t sel_o,
   output logic      mret_take_o
);
   logic              tmr_ok, sw_ok, irq_any, exc_any;
   logic [CODE_W-1:0] irq_code, exc_code;

   assign tmr_ok  = irq_timer_i & en_timer_i;
   assign sw_ok   = irq_soft_i & en_soft_i;
   assign irq_any = boundary_i & gie_i & (tmr_ok | sw_ok);
   assign exc_any = boundary_i & (ecall_i | ebreak_i | illegal_i);

   generate
      if (SOFT_OVER_TIMER) begin : g_sw_first
         assign irq_code = sw_ok ? CODE_IRQ_SW : CODE_IRQ_TMR;
      end else begin : g_tmr_first
         assign irq_code = tmr_ok ? CODE_IRQ_TMR : CODE_IRQ_SW;
      end
   endgenerate

   always_comb begin
      if (illegal_i)     exc_code = CODE_ILLEGAL;
      else if (ebreak_i) exc_code = CODE_BREAK;
      else               exc_code = CODE_ECALL;
   end

   always_comb begin
      sel_o.take   = irq_any | exc_any;
      sel_o.is_irq = irq_any;
      sel_o.code   = irq_any ? irq_code : exc_code;
   end

   assign mret_take_o = boundary_i & mret_i & ~(irq_any | exc_any);
endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  trap_sel_t       trap_i,
   input  logic [XLEN-1:0] epc_i,
   input  logic            mret_i,
   input  logic            sw_we_i,
   input  logic            sw_sel_i,
   input  logic [XLEN-1:0] sw_wdata_i,
   output logic [XLEN-1:0] mepc_o,
   output logic [XLEN-1:0] mcause_o,
   output logic            ie_o,
   output logic            pie_o
);
   localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("mtrap_csr: XLEN too small for status bits");
      end
   endgenerate

   logic [XLEN-1:0] mepc_q, mcause_q;
   logic            ie_q, pie_q;
   logic            unused_low;
   assign unused_low = ^{epc_i[1:0], sw_wdata_i[1:0]};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mepc_q   <= '0;
         mcause_q <= '0;
         ie_q     <= 1'b0;
         pie_q    <= 1'b0;
      end else if (trap_i.take) begin
         mepc_q   <= {epc_i[XLEN-1:2], 2'b00};
         mcause_q <= {trap_i.is_irq, {PAD_W{1'b0}}, trap_i.code};
         pie_q    <= ie_q;
         ie_q     <= 1'b0;
      end else if (mret_i) begin
         ie_q     <= pie_q;
         pie_q    <= 1'b1;
      end else if (sw_we_i) begin
         if (sw_sel_i == SEL_EPC) begin
            mepc_q <= {sw_wdata_i[XLEN-1:2], 2'b00};
         end else begin
            ie_q   <= sw_wdata_i[STAT_IE_BIT];
            pie_q  <= sw_wdata_i[STAT_PIE_BIT];
         end
      end
   end

   assign mepc_o   = mepc_q;
   assign mcause_o = mcause_q;
   assign ie_o     = ie_q;
   assign pie_o    = pie_q;

   // R7: trap entry stacks the enable and clears it
   p_trap_stack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_i.take |=> (!ie_q && (pie_q == $past(ie_q))));

   // R8: return pops the stacked enable and sets the stack
   p_mret_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mret_i && !trap_i.take) |=> ((ie_q == $past(pie_q)) && pie_q));
endmodule

// File: rtl/mtrap_redirect.sv
module mtrap_redirect #(
   parameter int unsigned XLEN = 32
) (
   input  logic            trap_take_i,
   input  logic            mret_take_i,
   input  logic [XLEN-1:0] mtvec_i,
   input  logic [XLEN-1:0] mepc_i,
   output logic            valid_o,
   output logic [XLEN-1:0] addr_o,
   output logic            flush_o
);
   logic unused_vec_low;
   assign unused_vec_low = ^mtvec_i[1:0];

   always_comb begin
      valid_o = trap_take_i | mret_take_i;
      flush_o = valid_o;
      if (trap_take_i)      addr_o = {mtvec_i[XLEN-1:2], 2'b00};
      else if (mret_take_i) addr_o = mepc_i;
      else                  addr_o = '0;
   end
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN            = 32,
   parameter bit          SOFT_OVER_TIMER = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            instr_valid_i,
   input  logic [XLEN-1:0] instr_pc_i,
   input  logic            exc_ecall_i,
   input  logic            exc_ebreak_i,
   input  logic            exc_illegal_i,
   input  logic            mret_i,
   input  logic            irq_timer_i,
   input  logic            irq_soft_i,
   input  logic            en_timer_i,
   input  logic            en_soft_i,
   input  logic [XLEN-1:0] mtvec_i,
   input  logic            csr_we_i,
   input  logic            csr_sel_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   output logic            redirect_valid_o,
   output logic [XLEN-1:0] redirect_addr_o,
   output logic            flush_o,
   output logic            retire_o,
   output logic            mepc_we_o,
   output logic            mcause_we_o,
   output logic [XLEN-1:0] mepc_o,
   output logic [XLEN-1:0] mcause_o,
   output logic            mstatus_mie_o,
   output logic            mstatus_mpie_o
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("mtrap_unit: XLEN must be 32 or 64");
      end
   endgenerate

   trap_sel_t trap;
   logic      mret_take, sw_apply;

   mtrap_arbiter #(.SOFT_OVER_TIMER(SOFT_OVER_TIMER)) i_arb (
      .boundary_i  (instr_valid_i),
      .ecall_i     (exc_ecall_i),
      .ebreak_i    (exc_ebreak_i),
      .illegal_i   (exc_illegal_i),
      .mret_i      (mret_i),
      .gie_i       (mstatus_mie_o),
      .irq_timer_i (irq_timer_i),
      .irq_soft_i  (irq_soft_i),
      .en_timer_i  (en_timer_i),
      .en_soft_i   (en_soft_i),
      .sel_o       (trap),
      .mret_take_o (mret_take)
   );

   // a write from a trapping instruction is cancelled with it
   assign sw_apply = csr_we_i & ~trap.take & ~mret_take;

   mtrap_csr #(.XLEN(XLEN)) i_csr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trap_i     (trap),
      .epc_i      (instr_pc_i),
      .mret_i     (mret_take),
      .sw_we_i    (sw_apply),
      .sw_sel_i   (csr_sel_i),
      .sw_wdata_i (csr_wdata_i),
      .mepc_o     (mepc_o),
      .mcause_o   (mcause_o),
      .ie_o       (mstatus_mie_o),
      .pie_o      (mstatus_mpie_o)
   );

   mtrap_redirect #(.XLEN(XLEN)) i_redir (
      .trap_take_i (trap.take),
      .mret_take_i (mret_take),
      .mtvec_i     (mtvec_i),
      .mepc_i      (mepc_o),
      .valid_o     (redirect_valid_o),
      .addr_o      (redirect_addr_o),
      .flush_o     (flush_o)
   );

   assign retire_o    = instr_valid_i & ~trap.take;
   assign mepc_we_o   = trap.take | (sw_apply & (csr_sel_i == SEL_EPC));
   assign mcause_we_o = trap.take;

   // R2: saved PC is exactly the trapping instruction's address
   p_epc_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap.take |=> (mepc_o == {$past(instr_pc_i[XLEN-1:2]), 2'b00}));

   // R3: an interrupt needs the global enable and a boundary
   p_irq_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap.take && trap.is_irq) |-> (mstatus_mie_o && instr_valid_i));

   // R4: a qualified interrupt always wins the cycle
   p_irq_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (instr_valid_i && mstatus_mie_o &&
       ((irq_timer_i && en_timer_i) || (irq_soft_i && en_soft_i)))
      |=> mcause_o[XLEN-1]);

   // R5: trap redirect goes to the aligned vector with a flush
   p_vec_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap.take |-> (redirect_valid_o && flush_o &&
                     (redirect_addr_o == {mtvec_i[XLEN-1:2], 2'b00})));

   // R6: a redirect never coexists with retirement of a trapping instruction
   p_no_retire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mcause_we_o |-> !retire_o);

   // R11: nothing happens without an instruction at the boundary
   p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !instr_valid_i |-> (!redirect_valid_o && !mcause_we_o));
endmodule

// File: tb/test_mtrap_unit.sv
`timescale 1ns / 1ps
module test_mtrap_unit;
   localparam int unsigned XLEN = 32;
   localparam bit Y = 1'b1;
   localparam bit N = 1'b0;
   localparam logic [31:0] SENT = 32'h0000_0ABC;

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] tvec;
      logic        gie;
      logic        valid;
      logic        ecall;
      logic        ebreak;
      logic        illegal;
      logic        tirq;
      logic        sirq;
      logic        ten;
      logic        sen;
      logic        trap;
      logic [31:0] cause;
      logic [31:0] vaddr;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      // R1 R2: environment call
      '{32'h100, 32'h1003, N, Y, Y, N, N, N, N, N, N, Y, 32'h0000000B, 32'h1000, 4'd2},
      // R2: breakpoint keeps own address
      '{32'h204, 32'h2001, N, Y, N, Y, N, N, N, N, N, Y, 32'h00000003, 32'h2000, 4'd2},
      // R1: illegal
      '{32'h308, 32'h80000102, N, Y, N, N, Y, N, N, N, N, Y, 32'h00000002, 32'h80000100, 4'd1},
      // R1: priority illegal first
      '{32'h40C, 32'h1000, N, Y, Y, Y, Y, N, N, N, N, Y, 32'h00000002, 32'h1000, 4'd1},
      // R1: breakpoint over environment call
      '{32'h410, 32'h1000, N, Y, Y, Y, N, N, N, N, N, Y, 32'h00000003, 32'h1000, 4'd1},
      // R3: timer
      '{32'h500, 32'h1003, Y, Y, N, N, N, Y, N, Y, N, Y, 32'h80000007, 32'h1000, 4'd3},
      // R3: software
      '{32'h504, 32'h1003, Y, Y, N, N, N, N, Y, N, Y, Y, 32'h80000003, 32'h1000, 4'd3},
      // R3: software wins over timer
      '{32'h508, 32'h1003, Y, Y, N, N, N, Y, Y, Y, Y, Y, 32'h80000003, 32'h1000, 4'd3},
      // R4: timer beats environment call
      '{32'h600, 32'h1000, Y, Y, Y, N, N, Y, N, Y, N, Y, 32'h80000007, 32'h1000, 4'd4},
      // R4: software beats illegal
      '{32'h604, 32'h1000, Y, Y, N, N, Y, N, Y, N, Y, Y, 32'h80000003, 32'h1000, 4'd4},
      // R3: masked by global enable
      '{32'h700, 32'h1000, N, Y, N, N, N, Y, N, Y, N, N, 32'h0, 32'h0, 4'd3},
      // R3: masked by line enable
      '{32'h704, 32'h1000, Y, Y, N, N, N, Y, N, N, Y, N, 32'h0, 32'h0, 4'd3},
      // R11: no boundary, exception ignored
      '{32'h708, 32'h1000, N, N, Y, N, N, N, N, N, N, N, 32'h0, 32'h0, 4'd11},
      // R11: no boundary, interrupt waits
      '{32'h70C, 32'h1000, Y, N, N, N, N, Y, N, Y, N, N, 32'h0, 32'h0, 4'd11},
      // R7: enable stacked on exception entry
      '{32'h710, 32'h1000, Y, Y, N, Y, N, N, N, N, N, Y, 32'h00000003, 32'h1000, 4'd7}
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            rst_ni;
   logic            instr_valid, exc_ecall, exc_ebreak, exc_illegal, mret;
   logic            irq_timer, irq_soft, en_timer, en_soft;
   logic [XLEN-1:0] instr_pc, mtvec, csr_wdata;
   logic            csr_we, csr_sel;
   logic            redirect_valid, flush, retire, mepc_we, mcause_we, mie, mpie;
   logic [XLEN-1:0] redirect_addr, mepc, mcause;

   int n_cmp = 0;
   int n_bad = 0;

   mtrap_unit i_mtrap_unit (
      .clk_i(clk), .rst_ni(rst_ni),
      .instr_valid_i(instr_valid), .instr_pc_i(instr_pc),
      .exc_ecall_i(exc_ecall), .exc_ebreak_i(exc_ebreak), .exc_illegal_i(exc_illegal),
      .mret_i(mret), .irq_timer_i(irq_timer), .irq_soft_i(irq_soft),
      .en_timer_i(en_timer), .en_soft_i(en_soft), .mtvec_i(mtvec),
      .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
      .redirect_valid_o(redirect_valid), .redirect_addr_o(redirect_addr),
      .flush_o(flush), .retire_o(retire), .mepc_we_o(mepc_we), .mcause_we_o(mcause_we),
      .mepc_o(mepc), .mcause_o(mcause), .mstatus_mie_o(mie), .mstatus_mpie_o(mpie)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      instr_valid = 1'b0; instr_pc = '0; exc_ecall = 1'b0; exc_ebreak = 1'b0;
      exc_illegal = 1'b0; mret = 1'b0; irq_timer = 1'b0; irq_soft = 1'b0;
      en_timer = 1'b0; en_soft = 1'b0; csr_we = 1'b0; csr_sel = 1'b0; csr_wdata = '0;
   endtask

   // called just after a rising edge; returns just after the next one
   task automatic sw_write(input logic sel, input logic [31:0] data);
      csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
      @(posedge clk); #1;
      idle();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_ni = 1'b0;
      mtvec  = 32'h1000;
      idle();
      repeat (3) @(posedge clk);
      #1 rst_ni = 1'b1;

      // R10: reset state
      check("R10 mepc", mepc, 32'h0);
      check("R10 mcause", mcause, 32'h0);
      check("R10 mie", {31'b0, mie}, 32'h0);
      check("R10 mpie", {31'b0, mpie}, 32'h0);
      check("R10 redirect", {31'b0, redirect_valid}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         sw_write(1'b1, VECS[v].gie ? 32'h8 : 32'h0);
         sw_write(1'b0, SENT);
         mtvec       = VECS[v].tvec;
         instr_pc    = VECS[v].pc;
         instr_valid = VECS[v].valid;
         exc_ecall   = VECS[v].ecall;
         exc_ebreak  = VECS[v].ebreak;
         exc_illegal = VECS[v].illegal;
         irq_timer   = VECS[v].tirq;
         irq_soft    = VECS[v].sirq;
         en_timer    = VECS[v].ten;
         en_soft     = VECS[v].sen;
         @(negedge clk);
         begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[v].req, v);
            check({t, " redirect(R5)"}, {31'b0, redirect_valid}, {31'b0, VECS[v].trap});
            check({t, " flush(R5)"}, {31'b0, flush}, {31'b0, VECS[v].trap});
            if (VECS[v].trap) check({t, " vector(R5)"}, redirect_addr, VECS[v].vaddr);
            check({t, " retire(R6)"}, {31'b0, retire},
                  {31'b0, VECS[v].valid & ~VECS[v].trap});
            check({t, " cause strobe"}, {31'b0, mcause_we}, {31'b0, VECS[v].trap});
            check({t, " epc strobe"}, {31'b0, mepc_we}, {31'b0, VECS[v].trap});
            @(posedge clk); #1;
            idle();
            check({t, " mepc(R2)"}, mepc, VECS[v].trap ? VECS[v].pc : SENT);
            if (VECS[v].trap) check({t, " mcause"}, mcause, VECS[v].cause);
            check({t, " mie(R7)"}, {31'b0, mie}, {31'b0, VECS[v].gie & ~VECS[v].trap});
            check({t, " mpie(R7)"}, {31'b0, mpie}, {31'b0, VECS[v].gie & VECS[v].trap});
         end
      end

      // R9: saved PC write clears low bits
      mtvec = 32'h1000;
      sw_write(1'b0, 32'h1234_5677);
      check("R9 mepc aligned", mepc, 32'h1234_5674);

      // R8: machine return
      sw_write(1'b1, 32'h80);
      check("R9 status write mpie", {31'b0, mpie}, 32'h1);
      instr_valid = 1'b1; instr_pc = 32'h40; mret = 1'b1;
      @(negedge clk);
      check("R8 redirect", {31'b0, redirect_valid}, 32'h1);
      check("R8 flush", {31'b0, flush}, 32'h1);
      check("R8 target", redirect_addr, 32'h1234_5674);
      check("R8 retire", {31'b0, retire}, 32'h1);
      check("R8 no cause write", {31'b0, mcause_we}, 32'h0);
      @(posedge clk); #1; idle();
      check("R8 mie restored", {31'b0, mie}, 32'h1);
      check("R8 mpie set", {31'b0, mpie}, 32'h1);
      check("R8 mepc kept", mepc, 32'h1234_5674);

      // R2 R9: handler skips the environment call itself
      instr_valid = 1'b1; instr_pc = 32'h600; exc_ecall = 1'b1;
      @(posedge clk); #1; idle();
      check("R2 ecall mepc", mepc, 32'h600);
      sw_write(1'b0, mepc + 32'd4);
      instr_valid = 1'b1; instr_pc = 32'h1010; mret = 1'b1;
      @(negedge clk);
      check("R9 skip target", redirect_addr, 32'h604);
      @(posedge clk); #1; idle();

      // R6: software write discarded by trapping instruction
      instr_valid = 1'b1; instr_pc = 32'h700; exc_ecall = 1'b1;
      csr_we = 1'b1; csr_sel = 1'b0; csr_wdata = 32'hDEAD_0000;
      @(negedge clk);
      check("R6 no retire", {31'b0, retire}, 32'h0);
      @(posedge clk); #1; idle();
      check("R6 write dropped", mepc, 32'h700);

      // R4: interrupt beats a machine return
      sw_write(1'b1, 32'h8);
      instr_valid = 1'b1; instr_pc = 32'h800; mret = 1'b1;
      irq_timer = 1'b1; en_timer = 1'b1;
      @(negedge clk);
      check("R4 goes to vector", redirect_addr, 32'h1000);
      @(posedge clk); #1; idle();
      check("R4 mepc is return pc", mepc, 32'h800);
      check("R4 cause timer", mcause, 32'h8000_0007);
      check("R7 mie cleared", {31'b0, mie}, 32'h0);
      check("R7 mpie stacked", {31'b0, mpie}, 32'h1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule